// File: doc/BRIEF.md
# Paged ROM-Socket Memory Controller

This block fills a 512-byte ROM socket with a larger backing store. The host presents a 9-bit address, an 8-bit data bus, an active-low chip enable and single-cycle read and write strobes. Address bit 8 picks one of two halves. Low selects a nonvolatile array of 8 KB (32 pages of 256 bytes). High selects a RAM of 2 KB (8 pages). Each half has its own page register. That register supplies the upper address bits sent to its memory, so the two halves can point at unrelated pages.

The top four offsets of every nonvolatile page form a register window. Offset 0xFC holds the nonvolatile page, 0xFD the RAM page, 0xFE a mode register and 0xFF a read-only flag register. The mode register does three things: it gates writes into the nonvolatile array (program mode), it clears both page registers on request, and it can hide the flag register so that offset 0xFF reaches the array. Firmware copies a routine into RAM and runs it from there while it rewrites nonvolatile pages and polls the busy flag.

Top module: `paged_rom_ctrl`

## Requirements
- R1: With chip enable low, address bit 8 high accesses RAM at {RAM page, addr[7:0]}. Bit 8 low, outside the register window, accesses the nonvolatile array at {NV page, addr[7:0]}. At most one memory select is active at a time.
- R2: With bit 8 low and addr[7:2] all ones, the access targets a register and neither memory select is active. Offsets: 0xFC is the NV page (5 bits, zero-extended on read), 0xFD the RAM page (3 bits), 0xFE mode, 0xFF flag. 0xFC to 0xFE are read/write.
- R3: Writing one page register leaves the other page register unchanged.
- R4: An active-low reset clears both page registers and all mode bits.
- R5: Writing the mode register with bit 1 set clears both page registers at the same edge. Bit 1 is not stored and reads as 0.
- R6: The flag register reads as {6'b0, program-mode bit, busy input}. A host write to it changes no register and no memory.
- R7: Mode bit 2 set hides the flag register. Offset 0xFF of the nonvolatile half then reads and writes the array like any other byte.
- R8: The data output enable is high only during a read strobe with chip enable low, including reads of the register window. It is never high during a write.
- R9: Mode bit 0 is the program-mode bit and drives the prog_mode output. A write to the nonvolatile array reaches it only while this bit is set.
- R10: A write to the RAM half always reaches the RAM at the paged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| host_addr | input | 9 | Host address; bit 8 selects the half |
| host_cs_n | input | 1 | Active-low chip enable |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_din | input | 8 | Write data from host |
| host_dout | output | 8 | Read data to host |
| host_dout_en | output | 1 | Host data bus drive enable |
| nv_addr | output | 13 | Nonvolatile array address |
| nv_cs_n | output | 1 | Nonvolatile array select |
| nv_we_n | output | 1 | Nonvolatile array write enable |
| nv_rdata | input | 8 | Nonvolatile array read data |
| nv_busy | input | 1 | Busy status of the nonvolatile array |
| ram_addr | output | 11 | RAM address |
| ram_cs_n | output | 1 | RAM select |
| ram_we_n | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data |
| mem_wdata | output | 8 | Write data to both memories |
| prog_mode | output | 1 | Program-mode control |

## Verification
Read data and the output enable are combinational. They are due in the same cycle that the read strobe is presented, so the monitor compares them at the falling edge of that cycle. Register and memory writes take effect at the rising edge that closes the write strobe, and their results are first read back in the following strobe cycle. Write pass-through and write suppression are checked directly in the bench's memory arrays one cycle after the strobe. Stimulus changes 1 ns after a rising edge, so no sample coincides with an input change.

// File: rtl/rsm_pkg.sv
`timescale 1ns/1ps
package rsm_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_NV   = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_REG  = 2'd3
    } tgt_e;

    // register index = host address bits [1:0] inside the window
    localparam logic [1:0] IDX_NVPG  = 2'd0;
    localparam logic [1:0] IDX_RAMPG = 2'd1;
    localparam logic [1:0] IDX_MODE  = 2'd2;
    localparam logic [1:0] IDX_FLAG  = 2'd3;

    localparam int MODE_PROG    = 0;
    localparam int MODE_CLR     = 1;
    localparam int MODE_FLAGOFF = 2;

    localparam int FLAG_BUSY = 0;
    localparam int FLAG_PROG = 1;
endpackage

// File: rtl/rsm_decode.sv
`timescale 1ns/1ps
module rsm_decode
    import rsm_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic           cs_n,
    input  logic [OFS_W:0] addr,
    input  logic           flag_off,
    output tgt_e           tgt,
    output logic [1:0]     idx
);
    logic in_window;

    always_comb begin
        idx       = addr[1:0];
        in_window = !addr[OFS_W] && (&addr[OFS_W-1:2]);
        tgt       = TGT_NONE;
        if (!cs_n) begin
            if (addr[OFS_W]) begin
                tgt = TGT_RAM;
            end else if (in_window && !(addr[1:0] == IDX_FLAG && flag_off)) begin
                tgt = TGT_REG;
            end else begin
                tgt = TGT_NV;
            end
        end
    end
endmodule

// File: rtl/rsm_regs.sv
`timescale 1ns/1ps
module rsm_regs
    import rsm_pkg::*;
#(
    parameter int NV_PG_W  = 5,
    parameter int RAM_PG_W = 3,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                nv_busy,
    output logic [NV_PG_W-1:0]  nv_page,
    output logic [RAM_PG_W-1:0] ram_page,
    output logic                prog,
    output logic                flag_off,
    output logic [DATA_W-1:0]   rdata
);
    typedef struct packed {
        logic [NV_PG_W-1:0]  nv_pg;
        logic [RAM_PG_W-1:0] ram_pg;
        logic                prog;
        logic                flag_off;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (idx)
                IDX_NVPG:  regs_d.nv_pg  = wdata[NV_PG_W-1:0];
                IDX_RAMPG: regs_d.ram_pg = wdata[RAM_PG_W-1:0];
                IDX_MODE: begin
                    regs_d.prog     = wdata[MODE_PROG];
                    regs_d.flag_off = wdata[MODE_FLAGOFF];
                    if (wdata[MODE_CLR]) begin
                        regs_d.nv_pg  = '0;
                        regs_d.ram_pg = '0;
                    end
                end
                default: ; // flag register is read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_NVPG:  rdata = DATA_W'(regs_q.nv_pg);
            IDX_RAMPG: rdata = DATA_W'(regs_q.ram_pg);
            IDX_MODE: begin
                rdata[MODE_PROG]    = regs_q.prog;
                rdata[MODE_FLAGOFF] = regs_q.flag_off;
            end
            default: begin
                rdata[FLAG_BUSY] = nv_busy;
                rdata[FLAG_PROG] = regs_q.prog;
            end
        endcase
    end

    assign nv_page  = regs_q.nv_pg;
    assign ram_page = regs_q.ram_pg;
    assign prog     = regs_q.prog;
    assign flag_off = regs_q.flag_off;

    AST_PAGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_MODE && wdata[MODE_CLR]) |=> (nv_page == '0 && ram_page == '0)); // R5
    AST_FLAG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_FLAG) |=> $stable(regs_q)); // R6
    AST_PAGE_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_RAMPG) |=> $stable(nv_page)); // R3
endmodule

// File: rtl/paged_rom_ctrl.sv
`timescale 1ns/1ps
module paged_rom_ctrl
    import rsm_pkg::*;
#(
    parameter int OFS_W    = 8,
    parameter int DATA_W   = 8,
    parameter int NV_PG_W  = 5,
    parameter int RAM_PG_W = 3,
    localparam int NV_AW   = NV_PG_W + OFS_W,
    localparam int RAM_AW  = RAM_PG_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W:0]    host_addr,
    input  logic              host_cs_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_dout_en,
    output logic [NV_AW-1:0]  nv_addr,
    output logic              nv_cs_n,
    output logic              nv_we_n,
    input  logic [DATA_W-1:0] nv_rdata,
    input  logic              nv_busy,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              prog_mode
);
    tgt_e                tgt;
    logic [1:0]          reg_idx;
    logic [NV_PG_W-1:0]  nv_page;
    logic [RAM_PG_W-1:0] ram_page;
    logic                flag_off;
    logic                reg_wr;
    logic [DATA_W-1:0]   reg_rdata;

    rsm_decode #(.OFS_W(OFS_W)) u_decode (
        .cs_n     (host_cs_n),
        .addr     (host_addr),
        .flag_off (flag_off),
        .tgt      (tgt),
        .idx      (reg_idx)
    );

    assign reg_wr = host_wr && (tgt == TGT_REG);

    rsm_regs #(
        .NV_PG_W  (NV_PG_W),
        .RAM_PG_W (RAM_PG_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .idx      (reg_idx),
        .wdata    (host_din),
        .nv_busy  (nv_busy),
        .nv_page  (nv_page),
        .ram_page (ram_page),
        .prog     (prog_mode),
        .flag_off (flag_off),
        .rdata    (reg_rdata)
    );

    always_comb begin
        nv_addr      = {nv_page, host_addr[OFS_W-1:0]};
        ram_addr     = {ram_page, host_addr[OFS_W-1:0]};
        mem_wdata    = host_din;
        nv_cs_n      = (tgt != TGT_NV);
        ram_cs_n     = (tgt != TGT_RAM);
        nv_we_n      = !((tgt == TGT_NV) && host_wr && prog_mode);
        ram_we_n     = !((tgt == TGT_RAM) && host_wr);
        host_dout_en = host_rd && (tgt != TGT_NONE);
        case (tgt)
            TGT_NV:  host_dout = nv_rdata;
            TGT_RAM: host_dout = ram_rdata;
            TGT_REG: host_dout = reg_rdata;
            default: host_dout = '0;
        endcase
        if (!host_dout_en) host_dout = '0;
    end

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~nv_cs_n, ~ram_cs_n})); // R1
    AST_WIN_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && !host_addr[OFS_W] && (&host_addr[OFS_W-1:2]) && host_addr[1:0] != 2'd3)
        |-> (nv_cs_n && ram_cs_n)); // R2
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n || !host_rd) |-> !host_dout_en); // R8
    AST_NV_WE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_we_n |-> (prog_mode && host_wr)); // R9
endmodule

// File: tb/paged_rom_ctrl_tb.sv
`timescale 1ns/1ps
module paged_rom_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  host_addr = '0;
    logic        host_cs_n = 1'b1;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_dout_en;
    logic [12:0] nv_addr;
    logic        nv_cs_n, nv_we_n;
    logic [7:0]  nv_rdata;
    logic        nv_busy = 1'b0;
    logic [10:0] ram_addr;
    logic        ram_cs_n, ram_we_n;
    logic [7:0]  ram_rdata;
    logic [7:0]  mem_wdata;
    logic        prog_mode;

    int checks = 0;
    int errors = 0;

    logic [7:0] nv_mem  [0:8191];
    logic [7:0] ram_mem [0:2047];
    logic [7:0] exp_q [$];
    string      req_q [$];

    always #2 clk = ~clk;

    paged_rom_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs_n(host_cs_n),
        .host_rd(host_rd), .host_wr(host_wr), .host_din(host_din),
        .host_dout(host_dout), .host_dout_en(host_dout_en),
        .nv_addr(nv_addr), .nv_cs_n(nv_cs_n), .nv_we_n(nv_we_n), .nv_rdata(nv_rdata),
        .nv_busy(nv_busy), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_rdata(ram_rdata), .mem_wdata(mem_wdata), .prog_mode(prog_mode)
    );

    function automatic logic [7:0] nv_init(int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic logic [7:0] ram_init(int a);
        return 8'(a * 13 + 1);
    endfunction

    initial begin
        for (int i = 0; i < 8192; i++) nv_mem[i] = nv_init(i);
        for (int i = 0; i < 2048; i++) ram_mem[i] = ram_init(i);
    end

    // memory models: synchronous write, combinational read
    always @(posedge clk) begin
        if (!nv_cs_n && !nv_we_n)   nv_mem[nv_addr]   <= mem_wdata;
        if (!ram_cs_n && !ram_we_n) ram_mem[ram_addr] <= mem_wdata;
    end
    assign nv_rdata  = nv_mem[nv_addr];
    assign ram_rdata = ram_mem[ram_addr];

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares read results at the falling edge of the strobe cycle
    always @(negedge clk) begin
        if (!host_cs_n && host_rd) begin
            if (exp_q.size() == 0) begin
                chk("R8", 8'h01, 8'h00);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, {7'b0, host_dout_en}, 8'h01);
                chk(r, host_dout, e);
            end
        end
        if (!host_cs_n && host_wr) chk("R8", {7'b0, host_dout_en}, 8'h00);
    end

    task automatic rd(logic [8:0] a, logic [7:0] e, string req);
        @(posedge clk); #1;
        host_addr = a; host_cs_n = 1'b0; host_rd = 1'b1;
        exp_q.push_back(e); req_q.push_back(req);
        @(posedge clk); #1;
        host_cs_n = 1'b1; host_rd = 1'b0;
    endtask

    task automatic wr(logic [8:0] a, logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; host_din = d; host_cs_n = 1'b0; host_wr = 1'b1;
        @(posedge clk); #1;
        host_cs_n = 1'b1; host_wr = 1'b0;
    endtask

    initial begin
        #(100000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4 reset state
        rd(9'h0FC, 8'h00, "R4"); rd(9'h0FD, 8'h00, "R4"); rd(9'h0FE, 8'h00, "R4");
        rd(9'h0FF, 8'h00, "R6");
        @(negedge clk); chk("R8", {7'b0, host_dout_en}, 8'h00);
        chk("R4", {7'b0, prog_mode}, 8'h00);

        // R1 plain decode on page 0
        rd(9'h000, nv_init(0), "R1");
        rd(9'h1FC, ram_init(8'hFC), "R1"); // A8 high: RAM, not the window (R2)

        // R10 RAM write on page 5
        wr(9'h0FD, 8'h05);
        wr(9'h123, 8'hA5);
        #1 chk("R10", ram_mem[5*256 + 8'h23], 8'hA5);
        rd(9'h123, 8'hA5, "R1");

        // R9 nonvolatile write blocked without program mode
        wr(9'h010, 8'h5A);
        #1 chk("R9", nv_mem[16], nv_init(16));
        rd(9'h010, nv_init(16), "R9");

        // R9 program mode on, NV page 7
        wr(9'h0FE, 8'h01);
        #1 chk("R9", {7'b0, prog_mode}, 8'h01);
        wr(9'h0FC, 8'h07);
        wr(9'h010, 8'h3C);
        #1 chk("R9", nv_mem[7*256 + 16], 8'h3C);

        // R3 independence
        rd(9'h010, 8'h3C, "R3");
        rd(9'h123, 8'hA5, "R3");
        wr(9'h0FD, 8'h02);
        rd(9'h010, 8'h3C, "R3");
        rd(9'h123, ram_init(2*256 + 8'h23), "R3");
        rd(9'h0FC, 8'h07, "R2"); rd(9'h0FD, 8'h02, "R2"); rd(9'h0FE, 8'h01, "R2");

        // R6 flag register
        nv_busy = 1'b1;
        rd(9'h0FF, 8'h03, "R6");
        wr(9'h0FF, 8'hAA);
        #1 chk("R6", nv_mem[7*256 + 255], nv_init(7*256 + 255));
        rd(9'h0FF, 8'h03, "R6");
        rd(9'h0FC, 8'h07, "R6"); rd(9'h0FE, 8'h01, "R6");

        // R7 flag hidden: offset 0xFF reaches the array
        wr(9'h0FE, 8'h05);
        rd(9'h0FF, nv_init(7*256 + 255), "R7");
        wr(9'h0FF, 8'h77);
        #1 chk("R7", nv_mem[7*256 + 255], 8'h77);
        rd(9'h0FF, 8'h77, "R7");
        rd(9'h0FE, 8'h05, "R7");
        rd(9'h0FC, 8'h07, "R2");

        // R5 clear via mode bit 1
        wr(9'h0FE, 8'h02);
        rd(9'h0FC, 8'h00, "R5"); rd(9'h0FD, 8'h00, "R5"); rd(9'h0FE, 8'h00, "R5");
        rd(9'h123, ram_init(8'h23), "R5");
        chk("R9", {7'b0, prog_mode}, 8'h00);

        // R4 reset mid-run
        wr(9'h0FC, 8'h03); wr(9'h0FD, 8'h04); wr(9'h0FE, 8'h05);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk); #1 rst_n = 1'b1;
        nv_busy = 1'b0;
        rd(9'h0FC, 8'h00, "R4"); rd(9'h0FD, 8'h00, "R4"); rd(9'h0FE, 8'h00, "R4");
        rd(9'h0FF, 8'h00, "R4");
        chk("R4", {7'b0, prog_mode}, 8'h00);

        @(posedge clk); #1;
        chk("R8", 8'(exp_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule